// File: doc/BRIEF.md
# Single-Accumulator Processor with Interrupt Entry and Return

This block is a small 16-bit processor built around one accumulator. It runs a fetch, decode, execute loop against a synchronous word-addressed memory port. The memory address and the write data always come from an internal address latch and an internal data latch. Every instruction word carries a 4-bit operation code in bits 15:12 and a 12-bit word address in bits 11:0. The processor moves words between memory and the accumulator, adds memory words into it, and stops on a halt code.

Once each instruction has executed, the processor tests one external interrupt request line. If the status word allows interrupts, it pushes the status word and then the program counter onto a stack in memory. The stack grows downward. The processor then raises a one-cycle acknowledge and jumps to a fixed handler address. A return code pops the two words back in reverse order. The status word holds three arithmetic flags, an interrupt-enable bit and a supervisor bit. It is visible on a port, and so are the program counter and the accumulator.

Top module: `acc_cpu`

## Requirements
- R1: The operation code sits in bits 15:12 of an instruction and the operand address in bits 11:0. Code 0x1 copies the addressed word into the accumulator, code 0x2 writes the accumulator to the addressed word, and code 0x5 adds the addressed word to the accumulator, modulo 2^16.
- R2: Reset sets the program counter to 0x300 and clears the accumulator and the status word. Each fetch reads the word at the program counter, latches it as the current instruction, and advances the counter by one.
- R3: Take the program 0x1940, 0x5941, 0x2941, 0xF000 at 0x300..0x303, with 0x0003 at 0x940 and 0x0002 at 0x941. It leaves the accumulator at 0x0005, memory word 0x941 at 0x0005, and the program counter at 0x304.
- R4: The status word has these bits: bit0 zero, bit1 negative, bit2 signed overflow, bit3 interrupt enable, bit4 supervisor. An add updates all three flags. A load updates zero and negative and keeps overflow. A store leaves the flags unchanged.
- R5: Code 0xF stops the processor. The halted output then stays high and no further read or write strobe appears.
- R6: Codes with no assigned meaning (for example 0x9) change neither the accumulator nor memory.
- R7: Code 0x6 sets the interrupt-enable bit and code 0x7 clears it.
- R8: The interrupt request is sampled only after an instruction has executed. While the enable bit is clear, a high request is ignored and there is no acknowledge.
- R9: When an interrupt is taken, the status word is written at the stack pointer and the program counter at the stack pointer minus one. The stack pointer starts at 0xFFF after reset. The acknowledge is high for exactly one cycle. Execution continues at 0x010 with the enable bit cleared and the supervisor bit set. The handler is not entered again until the status word is restored.
- R10: Code 0xE pops the program counter first and then the status word, so execution resumes at the interrupted instruction with the saved status.
- R11: The read and write strobes are never high in the same cycle. Read data is expected on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Word address of the current memory access |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Data to be written |
| mem_rdata | input | 16 | Read data, valid the cycle after the read strobe |
| irq | input | 1 | Interrupt request, level |
| irq_ack | output | 1 | One-cycle acknowledge when an interrupt is taken |
| halted | output | 1 | High once a halt code has executed |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |
| psw_o | output | 5 | Status word (flags, enable, supervisor) |

## Verification
Most internal faults surface at the memory port within a few cycles. A wrong program counter shows up at the next fetch address. A wrong accumulator shows up in the data of the next store. A wrong stack pointer or a wrong push order shows up in the two stack writes that follow an acknowledge. Flag faults appear on the status port as soon as the load or add retires, and again in the word pushed at the next interrupt. An enable bit that is not cleared would show as a second acknowledge while the handler is still running. For that reason the request is held high across the whole handler.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_BITS = 4;
   localparam int PSW_BITS = 5;

   localparam int PSW_Z   = 0;
   localparam int PSW_N   = 1;
   localparam int PSW_V   = 2;
   localparam int PSW_IE  = 3;
   localparam int PSW_SUP = 4;

   localparam logic [OPC_BITS-1:0] OP_LOAD  = 4'h1;
   localparam logic [OPC_BITS-1:0] OP_STORE = 4'h2;
   localparam logic [OPC_BITS-1:0] OP_ADD   = 4'h5;
   localparam logic [OPC_BITS-1:0] OP_EI    = 4'h6;
   localparam logic [OPC_BITS-1:0] OP_DI    = 4'h7;
   localparam logic [OPC_BITS-1:0] OP_RET   = 4'hE;
   localparam logic [OPC_BITS-1:0] OP_HALT  = 4'hF;

   typedef enum logic [3:0] {
      S_FADDR,   // present PC to the address latch
      S_FWAIT,   // read strobe on the port
      S_FLATCH,  // capture instruction, advance PC
      S_DECODE,  // launch operand access
      S_RWAIT,   // operand read strobe on the port
      S_RLATCH,  // operand arrives, update AC and flags
      S_WWAIT,   // store strobe on the port
      S_ICHECK,  // sample interrupt request
      S_IPUSH,   // second push, vector
      S_PWAIT1,  // pop PC strobe
      S_PPC,     // capture PC, launch status pop
      S_PWAIT2,  // pop status strobe
      S_PPSW,    // capture status
      S_HALT
   } cpu_state_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
   parameter int DATA_W = 16
) (
   input  logic              is_add,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] operand,
   input  logic              v_in,
   output logic [DATA_W-1:0] result,
   output logic              z_out,
   output logic              n_out,
   output logic              v_out
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] sum;

   always_comb begin
      sum    = acc_in + operand;
      result = is_add ? sum : operand;
      z_out  = (result == '0);
      n_out  = result[MSB];
      if (is_add)
         v_out = (acc_in[MSB] == operand[MSB]) && (sum[MSB] != acc_in[MSB]);
      else
         v_out = v_in;
   end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
   import acc_cpu_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] opc,
   input  logic             irq,
   input  logic             ie,
   output cpu_state_t       state
);
   cpu_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         S_FADDR:  nxt = S_FWAIT;
         S_FWAIT:  nxt = S_FLATCH;
         S_FLATCH: nxt = S_DECODE;
         S_DECODE: begin
            case (opc)
               OP_LOAD, OP_ADD: nxt = S_RWAIT;
               OP_STORE:        nxt = S_WWAIT;
               OP_RET:          nxt = S_PWAIT1;
               OP_HALT:         nxt = S_HALT;
               default:         nxt = S_ICHECK;
            endcase
         end
         S_RWAIT:  nxt = S_RLATCH;
         S_RLATCH: nxt = S_ICHECK;
         S_WWAIT:  nxt = S_ICHECK;
         S_ICHECK: nxt = (irq && ie) ? S_IPUSH : S_FADDR;
         S_IPUSH:  nxt = S_FADDR;
         S_PWAIT1: nxt = S_PPC;
         S_PPC:    nxt = S_PWAIT2;
         S_PWAIT2: nxt = S_PPSW;
         S_PPSW:   nxt = S_ICHECK;
         S_HALT:   nxt = S_HALT;
         default:  nxt = S_FADDR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= S_FADDR;
      else        state <= nxt;
   end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int               DATA_W    = 16,
   parameter int               ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] RESET_PC  = 12'h300,
   parameter logic [ADDR_W-1:0] STACK_TOP = 12'hFFF,
   parameter logic [ADDR_W-1:0] VECTOR    = 12'h010
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_re,
   output logic                mem_we,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   input  logic                irq,
   output logic                irq_ack,
   output logic                halted,
   output logic [ADDR_W-1:0]   pc_o,
   output logic [DATA_W-1:0]   acc_o,
   output logic [PSW_BITS-1:0] psw_o
);
   localparam int OPC_W = DATA_W - ADDR_W;
   localparam int PAD_S = DATA_W - PSW_BITS;

   if (OPC_W != OPC_BITS) begin : g_bad_split
      $error("acc_cpu: DATA_W - ADDR_W must equal the opcode width");
   end
   if (DATA_W < PSW_BITS + 1) begin : g_bad_width
      $error("acc_cpu: DATA_W too narrow to hold the status word");
   end

   cpu_state_t          state;
   logic [ADDR_W-1:0]   pc, mar, sp;
   logic [DATA_W-1:0]   ir, mbr, ac;
   logic [PSW_BITS-1:0] psw;
   logic                re_q, we_q, ack_q;
   logic [OPC_W-1:0]    opc;
   logic [ADDR_W-1:0]   opaddr;
   logic                take_irq;

   logic [DATA_W-1:0]   alu_res;
   logic                alu_z, alu_n, alu_v;

   assign opc      = ir[DATA_W-1:ADDR_W];
   assign opaddr   = ir[ADDR_W-1:0];
   assign take_irq = (state == S_ICHECK) && irq && psw[PSW_IE];

   acc_cpu_seq #(.OPC_W(OPC_W)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .opc   (opc),
      .irq   (irq),
      .ie    (psw[PSW_IE]),
      .state (state)
   );

   acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
      .is_add  (opc == OP_ADD),
      .acc_in  (ac),
      .operand (mem_rdata),
      .v_in    (psw[PSW_V]),
      .result  (alu_res),
      .z_out   (alu_z),
      .n_out   (alu_n),
      .v_out   (alu_v)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc    <= RESET_PC;
         sp    <= STACK_TOP;
         mar   <= '0;
         mbr   <= '0;
         ir    <= '0;
         ac    <= '0;
         psw   <= '0;
         re_q  <= 1'b0;
         we_q  <= 1'b0;
         ack_q <= 1'b0;
      end else begin
         re_q  <= 1'b0;
         we_q  <= 1'b0;
         ack_q <= 1'b0;
         case (state)
            S_FADDR: begin
               mar  <= pc;
               re_q <= 1'b1;
            end
            S_FLATCH: begin
               ir  <= mem_rdata;
               mbr <= mem_rdata;
               pc  <= pc + 1'b1;
            end
            S_DECODE: begin
               case (opc)
                  OP_LOAD, OP_ADD: begin
                     mar  <= opaddr;
                     re_q <= 1'b1;
                  end
                  OP_STORE: begin
                     mar  <= opaddr;
                     mbr  <= ac;
                     we_q <= 1'b1;
                  end
                  OP_RET: begin
                     mar  <= sp + 1'b1;
                     re_q <= 1'b1;
                  end
                  OP_EI: psw[PSW_IE] <= 1'b1;
                  OP_DI: psw[PSW_IE] <= 1'b0;
                  default: ;
               endcase
            end
            S_RLATCH: begin
               mbr        <= mem_rdata;
               ac         <= alu_res;
               psw[PSW_Z] <= alu_z;
               psw[PSW_N] <= alu_n;
               psw[PSW_V] <= alu_v;
            end
            S_ICHECK: begin
               if (take_irq) begin
                  mar   <= sp;
                  mbr   <= {{PAD_S{1'b0}}, psw};
                  we_q  <= 1'b1;
                  sp    <= sp - 1'b1;
                  ack_q <= 1'b1;
               end
            end
            S_IPUSH: begin
               mar          <= sp;
               mbr          <= {{OPC_W{1'b0}}, pc};
               we_q         <= 1'b1;
               sp           <= sp - 1'b1;
               pc           <= VECTOR;
               psw[PSW_IE]  <= 1'b0;
               psw[PSW_SUP] <= 1'b1;
            end
            S_PPC: begin
               pc   <= mem_rdata[ADDR_W-1:0];
               mar  <= sp + 2'd2;
               re_q <= 1'b1;
               sp   <= sp + 1'b1;
            end
            S_PPSW: begin
               psw <= mem_rdata[PSW_BITS-1:0];
               sp  <= sp + 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign mem_addr  = mar;
   assign mem_re    = re_q;
   assign mem_we    = we_q;
   assign mem_wdata = mbr;
   assign irq_ack   = ack_q;
   assign halted    = (state == S_HALT);
   assign pc_o      = pc;
   assign acc_o     = ac;
   assign psw_o     = psw;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
   parameter int               ADDR_W = 12,
   parameter int               PSW_W  = 5,
   parameter logic [ADDR_W-1:0] VECTOR = 12'h010
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_re,
   input logic              mem_we,
   input logic              halted,
   input logic              irq_ack,
   input logic [ADDR_W-1:0] pc_o,
   input logic [PSW_W-1:0]  psw_o
);
   // R11: the two strobes never coincide
   a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   // R5: halt is sticky
   a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R5: no memory traffic while halted
   a_r5_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (!mem_re && !mem_we));

   // R9: acknowledge lasts one cycle
   a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack);

   // R8: an interrupt is only taken with the enable bit set
   a_r8_ack_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> psw_o[3]);

   // R9: entry clears enable, sets supervisor, vectors
   a_r9_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> (!psw_o[3] && psw_o[4] && pc_o == VECTOR));

endmodule

bind acc_cpu acc_cpu_chk #(
   .ADDR_W (ADDR_W),
   .PSW_W  (acc_cpu_pkg::PSW_BITS),
   .VECTOR (VECTOR)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mem_re  (mem_re),
   .mem_we  (mem_we),
   .halted  (halted),
   .irq_ack (irq_ack),
   .pc_o    (pc_o),
   .psw_o   (psw_o)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic        mem_re, mem_we;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic        irq = 1'b0;
   logic        irq_ack, halted;
   logic [11:0] pc_o;
   logic [15:0] acc_o;
   logic [4:0]  psw_o;

   always #2.5 clk = ~clk;

   acc_cpu u_dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .irq(irq), .irq_ack(irq_ack), .halted(halted), .pc_o(pc_o),
      .acc_o(acc_o), .psw_o(psw_o)
   );

   logic [15:0] mem [0:4095];
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
   end

   int checks = 0, errors = 0;
   int mon_checks = 0, mon_errors = 0;
   int ack_total = 0, strobe_total = 0;
   logic [27:0] exp_q[$];

   // scoreboard monitor: every write must match the next expected item
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq_ack) ack_total++;
         if (mem_re || mem_we) strobe_total++;
         if (mem_re && mem_we) begin
            mon_checks++; mon_errors++;
            $display("FAIL R11 both strobes act=11 exp=not both");
         end
         if (mem_we) begin
            mon_checks++;
            if (exp_q.size() == 0) begin
               mon_errors++;
               $display("FAIL R1 unexpected write act=%h:%h exp=none", mem_addr, mem_wdata);
            end else begin
               logic [27:0] e;
               e = exp_q.pop_front();
               if ({mem_addr, mem_wdata} !== e) begin
                  mon_errors++;
                  $display("FAIL R1/R9 write act=%h:%h exp=%h:%h",
                           mem_addr, mem_wdata, e[27:16], e[15:0]);
               end
            end
         end
      end
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         $display("FAIL watchdog act=%0d exp=<150000 cycles", wd);
         $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errors + 1);
         $finish;
      end
   end

   task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic expect_write(input logic [11:0] a, input logic [15:0] d);
      exp_q.push_back({a, d});
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_halt();
      for (int i = 0; i < 3000; i++) begin
         if (halted) return;
         @(negedge clk);
      end
      chk(1'b0, "R5 halt not reached", {15'd0, halted}, 16'h0001);
   endtask

   task automatic end_run(input string tag);
      chk(exp_q.size() == 0, tag, exp_q.size(), 16'h0000);
      exp_q.delete();
   endtask

   initial begin
      int a0, s0;
      clear_mem();
      // R2: reset state
      @(negedge clk); @(negedge clk);
      chk(pc_o == 12'h300, "R2 reset pc", {4'h0, pc_o}, 16'h0300);
      chk(acc_o == 16'h0, "R2 reset acc", acc_o, 16'h0000);
      chk(psw_o == 5'h0, "R2 reset psw", {11'h0, psw_o}, 16'h0000);
      chk(!halted, "R5 not halted at reset", {15'h0, halted}, 16'h0000);

      // R3/R8: example program, request held high but interrupts disabled
      mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941;
      mem[12'h302] = 16'h2941; mem[12'h303] = 16'hF000;
      mem[12'h940] = 16'h0003; mem[12'h941] = 16'h0002;
      expect_write(12'h941, 16'h0005);
      irq = 1'b1;
      a0 = ack_total;
      do_reset();
      wait_halt();
      chk(acc_o == 16'h0005, "R3 acc", acc_o, 16'h0005);
      chk(mem[12'h941] == 16'h0005, "R3 mem 941", mem[12'h941], 16'h0005);
      chk(pc_o == 12'h304, "R2 R3 pc after halt", {4'h0, pc_o}, 16'h0304);
      chk(psw_o == 5'h00, "R4 flags after 3+2", {11'h0, psw_o}, 16'h0000);
      chk(ack_total == a0, "R8 no ack while disabled", ack_total - a0, 16'h0000);
      end_run("R3 missing writes");
      s0 = strobe_total;
      repeat (20) @(negedge clk);
      chk(halted, "R5 stays halted", {15'h0, halted}, 16'h0001);
      chk(strobe_total == s0, "R5 quiet when halted", strobe_total - s0, 16'h0000);
      irq = 1'b0;

      // R4/R6: overflow into sign bit, unassigned code between stores
      clear_mem();
      mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941; mem[12'h302] = 16'h2942;
      mem[12'h303] = 16'h9000; mem[12'h304] = 16'h2943; mem[12'h305] = 16'hF000;
      mem[12'h940] = 16'h7FFF; mem[12'h941] = 16'h0001;
      expect_write(12'h942, 16'h8000);
      expect_write(12'h943, 16'h8000);
      do_reset();
      wait_halt();
      chk(psw_o == 5'h06, "R4 add sets N and V", {11'h0, psw_o}, 16'h0006);
      chk(acc_o == 16'h8000, "R6 no-op keeps acc", acc_o, 16'h8000);
      chk(pc_o == 12'h306, "R2 pc count", {4'h0, pc_o}, 16'h0306);
      end_run("R6 missing writes");

      // R4: load of zero sets Z, clears N, keeps V; store keeps flags
      clear_mem();
      mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941; mem[12'h302] = 16'h1944;
      mem[12'h303] = 16'h2945; mem[12'h304] = 16'hF000;
      mem[12'h940] = 16'h7FFF; mem[12'h941] = 16'h0001; mem[12'h945] = 16'hAAAA;
      expect_write(12'h945, 16'h0000);
      do_reset();
      wait_halt();
      chk(psw_o == 5'h05, "R4 load keeps V", {11'h0, psw_o}, 16'h0005);
      chk(acc_o == 16'h0000, "R1 load zero", acc_o, 16'h0000);
      end_run("R4 missing writes");

      // R7/R9/R10: enable, interrupt, handler, return
      clear_mem();
      mem[12'h300] = 16'h6000; mem[12'h301] = 16'h1940; mem[12'h302] = 16'h5941;
      mem[12'h303] = 16'h2942; mem[12'h304] = 16'hF000;
      mem[12'h010] = 16'h1943; mem[12'h011] = 16'h2944; mem[12'h012] = 16'hE000;
      mem[12'h940] = 16'h0003; mem[12'h941] = 16'h0002; mem[12'h943] = 16'h0100;
      expect_write(12'hFFF, 16'h0008);
      expect_write(12'hFFE, 16'h0301);
      expect_write(12'h944, 16'h0100);
      expect_write(12'h942, 16'h0005);
      a0 = ack_total;
      irq = 1'b1;
      do_reset();
      for (int i = 0; i < 200 && !irq_ack; i++) @(negedge clk);
      chk(irq_ack, "R9 ack seen", {15'h0, irq_ack}, 16'h0001);
      @(negedge clk);
      chk(!irq_ack, "R9 ack one cycle", {15'h0, irq_ack}, 16'h0000);
      chk(pc_o == 12'h010, "R9 vector", {4'h0, pc_o}, 16'h0010);
      chk(psw_o == 5'h10, "R9 entry psw", {11'h0, psw_o}, 16'h0010);
      // hold the request through the handler: no re-entry expected
      for (int i = 0; i < 200 && !(mem_we && mem_addr == 12'h944); i++) @(negedge clk);
      irq = 1'b0;
      wait_halt();
      chk(ack_total - a0 == 1, "R9 single entry", ack_total - a0, 16'h0001);
      chk(psw_o == 5'h08, "R10 psw restored", {11'h0, psw_o}, 16'h0008);
      chk(pc_o == 12'h305, "R10 resumed pc", {4'h0, pc_o}, 16'h0305);
      chk(acc_o == 16'h0005, "R10 acc after resume", acc_o, 16'h0005);
      end_run("R9 missing writes");

      // R7: disable code blocks a later request
      clear_mem();
      mem[12'h300] = 16'h6000; mem[12'h301] = 16'h7000; mem[12'h302] = 16'h1940;
      mem[12'h303] = 16'h5941; mem[12'h304] = 16'h2942; mem[12'h305] = 16'hF000;
      mem[12'h940] = 16'h0003; mem[12'h941] = 16'h0002;
      expect_write(12'h942, 16'h0005);
      a0 = ack_total;
      do_reset();
      for (int i = 0; i < 200 && !(mem_re && mem_addr == 12'h302); i++) @(negedge clk);
      irq = 1'b1;
      wait_halt();
      irq = 1'b0;
      chk(ack_total == a0, "R7 disabled no ack", ack_total - a0, 16'h0000);
      chk(psw_o == 5'h00, "R7 enable cleared", {11'h0, psw_o}, 16'h0000);
      end_run("R7 missing writes");

      $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
      $finish;
   end
endmodule